// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a 56-bit physical address by reading 64-bit page table entries from memory, one table level at a time. A request carries the virtual address, the kind of access (load, store or fetch), the privilege of the requester and two relaxation flags: one lets loads read execute-only pages, the other lets supervisor code touch user pages. The request also carries the physical base of the first table and the level the walk starts at. Level 2 is the normal starting point.

The walker owns a simple memory read port. It issues one read, waits for the reply (data or an access error) and then decides what to do. It either descends to the next table, stops with a fault code, or stops with a success bundle. The bundle holds the physical address, the leaf entry, the address the leaf was read from, the level the leaf sat at and the accumulated global flag. Leaves found above level 0 map large pages. Their alignment is checked, and the unused page-number bits are filled in from the virtual address. Only one walk runs at a time. While a walk runs, `busy` is high, and new requests are ignored until the one-cycle `done` pulse has been issued.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req_valid` are 0. No memory read is issued while the walker is idle.
- R2: At level L the read address is the current table base plus 8 × the 9-bit index `vaddr[12+9L+8 : 12+9L]`. Reads are issued one per level, in descending level order, starting at `start_lvl` with base `root_base`. Each read is a single-cycle `mem_req_valid` pulse.
- R3: A read answered with `mem_rsp_err` = 1 ends the walk with `fault` = 1 and `fault_code` = 1 (access).
- R4: Entry bits are V=0, R=1, W=2, X=3, U=4, G=5, with the page number in bits 53:10. An entry with V=0, or with W=1 and R=0, ends the walk with `fault_code` = 2 (invalid). An entry with R=W=X=0 is a pointer. A pointer found at level 0 also gives code 2.
- R5: A pointer at level L>0 makes the next table base equal to its page number shifted left by 12. The walk continues at level L−1.
- R6: On success, `res_global` is the OR of the G bits of every entry read during the walk.
- R7: A leaf at level L>0 whose page number has any of its low 9L bits set ends the walk with `fault_code` = 3 (misaligned).
- R8: On success, `fault` = 0 and `fault_code` = 0. `res_paddr` equals {leaf page number OR (low 9L bits of the virtual page number), `vaddr[11:0]`}. `res_pte`, `res_pte_addr` and `res_level` are the leaf entry, its address and its level.
- R9: `req_acc` is encoded as 0 load, 1 store, 2 fetch, and `req_priv` as 1 supervisor, 0 user. A leaf gives `fault_code` = 4 (permission) in any of these cases:
  - a user request reaches a page with U=0;
  - a supervisor request reaches a U=1 page when `req_sum` is 0, or when the access is a fetch;
  - the rights do not allow the access: a load needs R, or X when `req_mxr` is 1; a store needs W; a fetch needs X.
  The permission check comes before the alignment check.
- R10: `busy` rises the cycle after a request is accepted and stays high through the one-cycle `done` pulse. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_vaddr | input | 39 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 1 | 1 supervisor, 0 user |
| req_mxr | input | 1 | Loads may use execute-only pages |
| req_sum | input | 1 | Supervisor may access user pages |
| root_base | input | 56 | Physical base of the first table |
| start_lvl | input | 2 | Level the walk starts at |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request pulse |
| mem_req_addr | output | 56 | Entry read address |
| mem_rsp_valid | input | 1 | Read reply valid |
| mem_rsp_data | input | 64 | Entry read data |
| mem_rsp_err | input | 1 | Read reply is an access error |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 3 | 0 none, 1 access, 2 invalid, 3 misaligned, 4 permission |
| res_paddr | output | 56 | Translated physical address |
| res_pte | output | 64 | Leaf entry |
| res_pte_addr | output | 56 | Address the leaf was read from |
| res_level | output | 2 | Level of the leaf |
| res_global | output | 1 | OR of G bits along the walk |

## Verification
The walker is tried on three kinds of mapping: a small page reached through three reads, an aligned large page at level 1, and a large page at level 2. The level-1 and level-2 cases show whether the bit merge and the alignment mask scale with the leaf level. Fault patterns are then placed at distinct depths: a missing table, an invalid leaf, a write-only leaf, a pointer at the bottom level and a misaligned large page. These show that each fault has its own priority and code. Permission patterns flip one flag at a time (user bit, SUM, MXR, access kind, privilege), so each rule of R9 is separated from the others. Further runs use varied reply latencies, a non-default start level, and requests held during a walk.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int VA_W    = 39;
    localparam int PA_W    = 56;
    localparam int PTE_W   = 64;
    localparam int OFS_W   = 12;
    localparam int IDX_W   = 9;
    localparam int NLVL    = 3;
    localparam int PPN_W   = PA_W - OFS_W;
    localparam int VPN_W   = VA_W - OFS_W;
    localparam int LVL_W   = $clog2(NLVL);
    localparam int PTE_SH  = $clog2(PTE_W / 8);
    localparam int RSVD_W  = PTE_W - PPN_W - 10;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ACCESS   = 3'd1,
        FLT_INVALID  = 3'd2,
        FLT_MISALIGN = 3'd3,
        FLT_PERM     = 3'd4
    } flt_e;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        sw;
        logic              d;
        logic              a;
        logic              g;
        logic              u;
        logic              x;
        logic              w;
        logic              r;
        logic              v;
    } pte_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } wstate_e;

    typedef struct packed {
        logic [PA_W-1:0]  paddr;
        logic [PTE_W-1:0] pte;
        logic [PA_W-1:0]  pte_addr;
        logic [LVL_W-1:0] level;
        logic             global_f;
    } walk_res_t;

    function automatic logic [PPN_W-1:0] low_mask(input logic [LVL_W-1:0] lvl);
        logic [PPN_W-1:0] m;
        for (int i = 0; i < PPN_W; i++) begin
            m[i] = (i < int'(lvl) * IDX_W);
        end
        return m;
    endfunction

    function automatic logic entry_invalid(input logic v, input logic r, input logic w);
        return !v || (w && !r);
    endfunction

    function automatic logic entry_is_ptr(input logic r, input logic w, input logic x);
        return !r && !w && !x;
    endfunction

endpackage

// File: rtl/pgwalk_index.sv
module pgwalk_index
    import pgwalk_pkg::*;
(
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    input  logic [PA_W-1:0]  base,
    output logic [PA_W-1:0]  pte_addr
);
    localparam int PAD_W = PA_W - IDX_W - PTE_SH;

    logic [IDX_W-1:0] slice [NLVL];
    logic [IDX_W-1:0] idx;

    for (genvar g = 0; g < NLVL; g++) begin : g_slice
        assign slice[g] = vpn[g*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (level == i[LVL_W-1:0]) idx = slice[i];
        end
    end

    assign pte_addr = base + {{PAD_W{1'b0}}, idx, {PTE_SH{1'b0}}};
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
    import pgwalk_pkg::*;
(
    input  logic       pr,
    input  logic       pw,
    input  logic       px,
    input  logic       pu,
    input  logic [1:0] acc,
    input  logic       sup,
    input  logic       mxr,
    input  logic       sum,
    output logic       ok
);
    logic priv_ok;
    logic right_ok;

    always_comb begin
        if (!sup) priv_ok = pu;
        else if (pu) priv_ok = sum && (acc != ACC_FETCH);
        else priv_ok = 1'b1;
    end

    always_comb begin
        unique case (acc)
            ACC_LOAD:  right_ok = pr || (px && mxr);
            ACC_STORE: right_ok = pw;
            ACC_FETCH: right_ok = px;
            default:   right_ok = 1'b0;
        endcase
    end

    assign ok = priv_ok && right_ok;
endmodule

// File: rtl/pgwalk_leaf.sv
module pgwalk_leaf
    import pgwalk_pkg::*;
(
    input  logic [PPN_W-1:0] ppn,
    input  logic [VPN_W-1:0] vpn,
    input  logic [OFS_W-1:0] ofs,
    input  logic [LVL_W-1:0] level,
    output logic             misaligned,
    output logic [PA_W-1:0]  paddr
);
    logic [PPN_W-1:0] mask;
    logic [PPN_W-1:0] vpn_ext;

    assign mask       = low_mask(level);
    assign vpn_ext    = {{(PPN_W-VPN_W){1'b0}}, vpn};
    assign misaligned = |(ppn & mask);
    assign paddr      = {ppn | (vpn_ext & mask), ofs};
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic             req_priv,
    input  logic             req_mxr,
    input  logic             req_sum,
    input  logic [PA_W-1:0]  root_base,
    input  logic [LVL_W-1:0] start_lvl,
    output logic             busy,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    input  logic             mem_rsp_err,
    output logic             done,
    output logic             fault,
    output logic [2:0]       fault_code,
    output logic [PA_W-1:0]  res_paddr,
    output logic [PTE_W-1:0] res_pte,
    output logic [PA_W-1:0]  res_pte_addr,
    output logic [LVL_W-1:0] res_level,
    output logic             res_global
);
    wstate_e          state_q;
    logic [VPN_W-1:0] vpn_q;
    logic [OFS_W-1:0] ofs_q;
    logic [1:0]       acc_q;
    logic             sup_q, mxr_q, sum_q;
    logic [PA_W-1:0]  base_q;
    logic [LVL_W-1:0] lvl_q;
    logic             glob_q;
    walk_res_t        res_q;
    flt_e             code_q;

    pte_t             ent;
    logic [PA_W-1:0]  cur_addr;
    logic             perm_ok;
    logic             mis;
    logic [PA_W-1:0]  leaf_pa;
    logic             glob_nx;
    logic             descend;
    flt_e             step_code;

    assign ent     = pte_t'(mem_rsp_data);
    assign glob_nx = glob_q | ent.g;

    pgwalk_index u_index (
        .vpn      (vpn_q),
        .level    (lvl_q),
        .base     (base_q),
        .pte_addr (cur_addr)
    );

    pgwalk_perm u_perm (
        .pr  (ent.r),
        .pw  (ent.w),
        .px  (ent.x),
        .pu  (ent.u),
        .acc (acc_q),
        .sup (sup_q),
        .mxr (mxr_q),
        .sum (sum_q),
        .ok  (perm_ok)
    );

    pgwalk_leaf u_leaf (
        .ppn        (ent.ppn),
        .vpn        (vpn_q),
        .ofs        (ofs_q),
        .level      (lvl_q),
        .misaligned (mis),
        .paddr      (leaf_pa)
    );

    // Classify the returned entry; priority: access, invalid, pointer, permission, alignment.
    always_comb begin
        descend   = 1'b0;
        step_code = FLT_NONE;
        if (mem_rsp_err) begin
            step_code = FLT_ACCESS;
        end else if (entry_invalid(ent.v, ent.r, ent.w)) begin
            step_code = FLT_INVALID;
        end else if (entry_is_ptr(ent.r, ent.w, ent.x)) begin
            if (lvl_q == '0) step_code = FLT_INVALID;
            else descend = 1'b1;
        end else if (!perm_ok) begin
            step_code = FLT_PERM;
        end else if (mis) begin
            step_code = FLT_MISALIGN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
            ofs_q   <= '0;
            acc_q   <= '0;
            sup_q   <= 1'b0;
            mxr_q   <= 1'b0;
            sum_q   <= 1'b0;
            base_q  <= '0;
            lvl_q   <= '0;
            glob_q  <= 1'b0;
            res_q   <= '0;
            code_q  <= FLT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vpn_q   <= req_vaddr[VA_W-1:OFS_W];
                        ofs_q   <= req_vaddr[OFS_W-1:0];
                        acc_q   <= req_acc;
                        sup_q   <= req_priv;
                        mxr_q   <= req_mxr;
                        sum_q   <= req_sum;
                        base_q  <= root_base;
                        lvl_q   <= start_lvl;
                        glob_q  <= 1'b0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (descend) begin
                            base_q  <= {ent.ppn, {OFS_W{1'b0}}};
                            lvl_q   <= lvl_q - 1'b1;
                            glob_q  <= glob_nx;
                            state_q <= ST_ISSUE;
                        end else begin
                            code_q <= step_code;
                            if (step_code == FLT_NONE) begin
                                res_q.paddr    <= leaf_pa;
                                res_q.pte      <= mem_rsp_data;
                                res_q.pte_addr <= cur_addr;
                                res_q.level    <= lvl_q;
                                res_q.global_f <= glob_nx;
                            end else begin
                                res_q <= '0;
                            end
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign mem_req_addr  = cur_addr;
    assign done          = (state_q == ST_DONE);
    assign fault         = (code_q != FLT_NONE);
    assign fault_code    = code_q;
    assign res_paddr     = res_q.paddr;
    assign res_pte       = res_q.pte;
    assign res_pte_addr  = res_q.pte_addr;
    assign res_level     = res_q.level;
    assign res_global    = res_q.global_f;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk
    import pgwalk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             busy,
    input logic             mem_req_valid,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             done,
    input logic             fault,
    input logic [2:0]       fault_code,
    input logic [PA_W-1:0]  res_paddr,
    input logic [PA_W-1:0]  res_pte_addr
);
    logic [OFS_W-1:0] ofs_seen;

    always_ff @(posedge clk) begin
        if (rst) ofs_seen <= '0;
        else if (req_valid && !busy) ofs_seen <= req_vaddr[OFS_W-1:0];
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid && !done);

    p_one_read_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    p_addr_align_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr[PTE_SH-1:0] == '0);

    p_fault_code_r3: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> fault_code inside {3'd1, 3'd2, 3'd3, 3'd4});

    p_offset_r8: assert property (@(posedge clk) disable iff (rst)
        done && !fault |-> res_paddr[OFS_W-1:0] == ofs_seen && res_pte_addr[PTE_SH-1:0] == '0);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy |=> busy && mem_req_valid);
endmodule

bind pgwalk_top pgwalk_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .fault         (fault),
    .fault_code    (fault_code),
    .res_paddr     (res_paddr),
    .res_pte_addr  (res_pte_addr)
);

// File: tb/pgwalk_top_test.sv
`timescale 1ns/1ps
module pgwalk_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [38:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_priv = 1'b0, req_mxr = 1'b0, req_sum = 1'b0;
    logic [55:0] root_base = '0;
    logic [1:0]  start_lvl = '0;
    logic        busy, mem_req_valid, done, fault, res_global;
    logic [55:0] mem_req_addr, res_paddr, res_pte_addr;
    logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [63:0] mem_rsp_data = '0, res_pte;
    logic [2:0]  fault_code;
    logic [1:0]  res_level;

    int nchk = 0, nfail = 0, cyc = 0, lat = 1, cnt = 0;
    logic [63:0] pmem [logic [55:0]];
    logic [55:0] expq [$];
    logic [55:0] pend_addr;

    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                           FU = 8'h10, FG = 8'h20, FA = 8'h40, FD = 8'h80;

    always #5 clk = ~clk;

    pgwalk_top uut (.*);

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    // Memory responder and per-read address comparison (R2)
    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_err   <= !pmem.exists(pend_addr);
                mem_rsp_data  <= pmem.exists(pend_addr) ? pmem[pend_addr] : 64'h0;
            end
        end
        if (!rst && mem_req_valid) begin
            if (expq.size() == 0) begin
                check("R10", "unexpected read", {8'h0, mem_req_addr}, 64'h0);
                nchk--;
                nfail++;
                $display("FAIL R10 read while idle: actual 1 expected 0");
            end else begin
                check("R2", "read address", {8'h0, mem_req_addr}, {8'h0, expq.pop_front()});
            end
            pend_addr = mem_req_addr;
            cnt = lat;
        end
    end

    function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [7:0] f);
        return {10'h0, ppn, 2'b00, f};
    endfunction

    function automatic logic [55:0] tbl(input int l);
        return 56'h8000_0000 + 56'(2 - l) * 56'h1000;
    endfunction

    function automatic logic [55:0] slot(input logic [55:0] base, input logic [38:0] va, input int l);
        return base + 56'((((va >> 12) >> (9 * l)) & 39'h1ff) * 8);
    endfunction

    // Build a path of pointers from level 2 down to the leaf level.
    task automatic build(input logic [38:0] va, input int leaf_lvl, input logic [63:0] leaf, input logic [7:0] top_flags);
        pmem.delete();
        for (int l = 2; l > leaf_lvl; l--) begin
            logic [55:0] nxt;
            nxt = tbl(l - 1);
            pmem[slot(tbl(l), va, l)] = mk(nxt[55:12], (l == 2) ? top_flags : FV);
        end
        pmem[slot(tbl(leaf_lvl), va, leaf_lvl)] = leaf;
    endtask

    // Behavioural reference of a whole walk; pushes every expected read address.
    task automatic model(input logic [38:0] va, input logic [1:0] acc, input logic spv, input logic mxr,
                         input logic sum, input logic [55:0] root, input int start,
                         output logic [2:0] code, output logic [55:0] pa, output logic [63:0] pte,
                         output logic [55:0] pta, output int lvl_o, output logic glob);
        int lvl;
        logic [55:0] base, a;
        logic [63:0] p;
        logic [43:0] ppn, msk;
        logic ok;
        lvl = start; base = root; glob = 1'b0; code = 3'd0; pa = '0; pte = '0; pta = '0; lvl_o = 0;
        forever begin
            a = slot(base, va, lvl);
            expq.push_back(a);
            if (!pmem.exists(a)) begin code = 3'd1; return; end
            p = pmem[a];
            glob = glob | p[5];
            if (!p[0] || (p[2] && !p[1])) begin code = 3'd2; return; end
            ppn = p[53:10];
            if (p[3:1] == 3'b000) begin
                if (lvl == 0) begin code = 3'd2; return; end
                base = {ppn, 12'h0};
                lvl = lvl - 1;
                continue;
            end
            ok = 1'b1;
            if (!spv && !p[4]) ok = 1'b0;
            if (spv && p[4] && (!sum || acc == 2'd2)) ok = 1'b0;
            case (acc)
                2'd0: if (!(p[1] || (p[3] && mxr))) ok = 1'b0;
                2'd1: if (!p[2]) ok = 1'b0;
                2'd2: if (!p[3]) ok = 1'b0;
                default: ok = 1'b0;
            endcase
            if (!ok) begin code = 3'd4; return; end
            msk = (44'd1 << (9 * lvl)) - 44'd1;
            if ((ppn & msk) != 0) begin code = 3'd3; return; end
            pa = {ppn | ({17'h0, va[38:12]} & msk), va[11:0]};
            pte = p; pta = a; lvl_o = lvl;
            return;
        end
    endtask

    task automatic run(input string req, input logic [38:0] va, input logic [1:0] acc, input logic spv,
                       input logic mxr, input logic sum, input logic [55:0] root, input int start,
                       input int latency, input logic hold_req);
        logic [2:0] ec; logic [55:0] epa, epta; logic [63:0] epte; int elvl; logic eg;
        int waited;
        lat = latency;
        model(va, acc, spv, mxr, sum, root, start, ec, epa, epte, epta, elvl, eg);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_priv = spv;
        req_mxr = mxr; req_sum = sum; root_base = root; start_lvl = 2'(start);
        @(negedge clk);
        check("R10", "busy after accept", {63'h0, busy}, 64'h1);
        if (hold_req) begin
            req_vaddr = va ^ 39'h7f_ffff_f000;
            root_base = 56'h0;
        end else begin
            req_valid = 1'b0;
        end
        waited = 0;
        while (!done && waited < 200) begin
            @(negedge clk);
            waited++;
            if (!done) check("R10", "busy during walk", {63'h0, busy}, 64'h1);
        end
        req_valid = 1'b0;
        check(req, "done seen", {63'h0, done}, 64'h1);
        check(req, "fault", {63'h0, fault}, {63'h0, ec != 3'd0});
        check(req, "fault_code", {61'h0, fault_code}, {61'h0, ec});
        if (ec == 3'd0) begin
            check("R8", "res_paddr", {8'h0, res_paddr}, {8'h0, epa});
            check("R8", "res_pte", res_pte, epte);
            check("R8", "res_pte_addr", {8'h0, res_pte_addr}, {8'h0, epta});
            check("R8", "res_level", {62'h0, res_level}, 64'(elvl));
            check("R6", "res_global", {63'h0, res_global}, {63'h0, eg});
        end
        @(negedge clk);
        check("R10", "done pulse ends", {62'h0, done, busy}, 64'h0);
        repeat (3) @(negedge clk);
        check("R2", "all reads issued", 64'(expq.size()), 64'h0);
        expq.delete();
    endtask

    initial begin
        logic [38:0] va;
        va = 39'h12_3456_789a;
        repeat (3) @(negedge clk);
        check("R1", "reset outputs", {61'h0, busy, done, mem_req_valid}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "idle after reset", {61'h0, busy, done, mem_req_valid}, 64'h0);

        // R2 R5 R8: small page through three levels, two latencies
        build(va, 0, mk(44'h12345, FV | FR | FW | FA | FD), FV);
        run("R8", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        run("R5", va, 2'd1, 1'b1, 1'b0, 1'b0, tbl(2), 2, 4, 1'b0);
        // R6: G only on the top pointer
        build(va, 0, mk(44'h12345, FV | FR | FA), FV | FG);
        run("R6", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 2, 1'b0);
        // R8: aligned large pages at levels 1 and 2
        build(va, 1, mk(44'h12200, FV | FX | FA), FV);
        run("R8", va, 2'd2, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        build(va, 2, mk(44'h40000, FV | FR | FG), FV);
        run("R8", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        // R7: misaligned large pages
        build(va, 2, mk(44'h40001, FV | FR), FV);
        run("R7", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        build(va, 1, mk(44'h12300, FV | FR), FV);
        run("R7", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        // R3: missing bottom table
        build(va, 0, mk(44'h1, FV | FR), FV);
        pmem.delete(slot(tbl(0), va, 0));
        run("R3", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 2, 1'b0);
        // R4: invalid at level 1, write-only leaf, pointer at level 0
        build(va, 1, mk(44'h0, 8'h00), FV);
        run("R4", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        build(va, 0, mk(44'h55, FV | FW), FV);
        run("R4", va, 2'd1, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        build(va, 0, mk(44'h55, FV), FV);
        run("R4", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        // R9: permission rules, one flag at a time
        build(va, 0, mk(44'h777, FV | FR | FX | FU), FV);
        run("R9", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        run("R9", va, 2'd0, 1'b1, 1'b0, 1'b1, tbl(2), 2, 1, 1'b0);
        run("R9", va, 2'd2, 1'b1, 1'b0, 1'b1, tbl(2), 2, 1, 1'b0);
        run("R9", va, 2'd2, 1'b0, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        run("R9", va, 2'd1, 1'b0, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        build(va, 0, mk(44'h777, FV | FX), FV);
        run("R9", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        run("R9", va, 2'd0, 1'b1, 1'b1, 1'b0, tbl(2), 2, 1, 1'b0);
        run("R9", va, 2'd0, 1'b0, 1'b1, 1'b0, tbl(2), 2, 1, 1'b0);
        build(va, 1, mk(44'h12300, FV | FR), FV);
        run("R9", va, 2'd1, 1'b1, 1'b0, 1'b0, tbl(2), 2, 1, 1'b0);
        // R2: start at level 1
        build(va, 0, mk(44'habcde, FV | FR | FW), FV);
        run("R2", va, 2'd1, 1'b1, 1'b0, 1'b0, tbl(1), 1, 3, 1'b0);
        // R10: request held high during a walk is ignored
        build(va, 0, mk(44'h31337, FV | FR | FG), FV);
        run("R10", va, 2'd0, 1'b1, 1'b0, 1'b0, tbl(2), 2, 2, 1'b1);
        repeat (4) @(negedge clk);
        check("R10", "idle after held request", {63'h0, busy}, 64'h0);
        finish_run();
    end
endmodule